// File: doc/BRIEF.md
# Two-Channel Serial Interrupt and Vector Unit

This block keeps the external/status interrupt state of a two-channel serial controller and drives its interrupt request. Each channel watches a carrier-detect input. When that input changes level and the channel's edge-capture enable is set, the channel latches a pending flag and records the event in a status byte. A channel asks for service when its pending flag is set and its external-interrupt enable is set. A shared master register gates the combined request, and the shared vector register is read back with a 3-bit code for the winning channel written into it.

Software reaches the block through a plain register port: a channel select, a 4-bit register index, a write strobe with data, and a read strobe. Read data is registered. The request output is registered, and a one-cycle strobe marks every change in its level.

Top module: `sirq_top`

## Requirements
- R1: A synchronous reset clears every mask, pending flag, status byte, the vector and the master register. It drives `irq` and `irq_chg` low and samples `cd_in`, so a steady input causes no event after reset.
- R2: A channel latches its pending flag, and sets bit 3 of its status byte (register 15), when its `cd_in` bit differs from the previous cycle's level and bit 3 of its edge-capture register (written at register 15) is 1. With that bit at 0 the change leaves pending and status unchanged.
- R3: A `cd_in` level that stays the same sets nothing.
- R4: Writing register 0 with bits 5:3 equal to 3'b010 clears that channel's pending flag and its whole status byte. If a carrier-detect change lands in the same cycle, the change wins.
- R5: A channel requests service when bit 0 of its enable register (register 1) is 1 and its pending flag is set.
- R6: `irq` is high exactly when master bit 3 (register 9) is 1 and at least one channel requests service. It follows its inputs with one register of delay.
- R7: Reading register 2 on channel 0 returns the vector (register 2, shared). If a channel requests service, a 3-bit code replaces a field of the vector: code 1 when channel 0 requests, otherwise code 5 for channel 1. The field sits at bits 3:1 when master bit 4 is 0 and at bits 6:4 when it is 1. With no request the vector comes back unchanged.
- R8: Register 0 reads the current carrier-detect level in bit 3, with all other bits 0. Register 15 reads the status byte. Register 2 on channel 1 reads the raw vector. Every other index reads 0.
- R9: `irq_chg` is high for exactly the cycles in which `irq` takes a new value.
- R10: `rd_data` holds the result of a read from the clock edge that samples `rd_en` until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan | input | 1 | Channel select for the access |
| reg_idx | input | 4 | Register index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| cd_in | input | 2 | Carrier-detect levels, one bit per channel |
| irq | output | 1 | Registered combined interrupt request |
| irq_chg | output | 1 | One-cycle strobe on every `irq` change |

## Verification
A carrier-detect change applied before edge E1 sets pending and status at E1. `irq` and `irq_chg` change at E2. A read sampled at one edge has its data ready after that edge. The bench drives inputs on the falling edge and samples on the next falling edge after the edge that is due. It counts `irq_chg` pulses across the whole window after each flip, so a missing pulse or an extra one is caught. The sweep covers every combination of master bits, enables, edge-capture bits and flip pattern, and checks the interrupt, the merged vector and both status registers for each.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int DW = 8;
  localparam int NCH = 2;
  localparam logic [3:0] IDX_CMD  = 4'd0;
  localparam logic [3:0] IDX_EN   = 4'd1;
  localparam logic [3:0] IDX_VEC  = 4'd2;
  localparam logic [3:0] IDX_MSTR = 4'd9;
  localparam logic [3:0] IDX_EXT  = 4'd15;
  localparam logic [2:0] CMD_CLR_EXT = 3'b010;
  localparam int BIT_CD = 3;
  localparam int BIT_MIE = 3;
  localparam int BIT_HIPOS = 4;
  localparam logic [2:0] CODE_CH0 = 3'd1;
  localparam logic [2:0] CODE_CH1 = 3'd5;
endpackage

// File: rtl/sirq_chan.sv
module sirq_chan
  import sirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cd_in,
  input  logic          wr_en,
  input  logic [3:0]    reg_idx,
  input  logic [DW-1:0] wr_data,
  output logic          req,
  output logic          cd_lvl,
  output logic [DW-1:0] stat
);
  logic en_r, cap_r, pend_r;
  logic [DW-1:0] stat_r;
  logic cd_q, edge_ev, clr_cmd;

  assign edge_ev = (cd_in != cd_q) && cap_r;
  assign clr_cmd = wr_en && (reg_idx == IDX_CMD) && (wr_data[5:3] == CMD_CLR_EXT);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r   <= 1'b0;
      cap_r  <= 1'b0;
      pend_r <= 1'b0;
      stat_r <= '0;
      cd_q   <= cd_in;
    end else begin
      cd_q <= cd_in;
      if (wr_en && reg_idx == IDX_EN)  en_r  <= wr_data[0];
      if (wr_en && reg_idx == IDX_EXT) cap_r <= wr_data[BIT_CD];
      if (edge_ev) begin
        pend_r         <= 1'b1;
        stat_r[BIT_CD] <= 1'b1;
      end else if (clr_cmd) begin
        pend_r <= 1'b0;
        stat_r <= '0;
      end
    end
  end

  assign req    = en_r && pend_r;
  assign cd_lvl = cd_q;
  assign stat   = stat_r;

  assert_pend_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_r) |-> $past(cd_in != cd_q && cap_r));
  assert_steady_no_event_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(cd_in == cd_q) && !$past(wr_en)) |-> $stable(stat_r));
endmodule

// File: rtl/sirq_vec.sv
module sirq_vec
  import sirq_pkg::*;
(
  input  logic [DW-1:0]  vec,
  input  logic           hi_pos,
  input  logic [NCH-1:0] req,
  output logic [DW-1:0]  vec_out
);
  logic [2:0] code;
  logic       any;

  always_comb begin
    any  = |req;
    code = req[0] ? CODE_CH0 : CODE_CH1;
    vec_out = vec;
    if (any) begin
      if (hi_pos) vec_out[6:4] = code;
      else        vec_out[3:1] = code;
    end
  end
endmodule

// File: rtl/sirq_top.sv
module sirq_top
  import sirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          chan,
  input  logic [3:0]    reg_idx,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic [1:0]    cd_in,
  output logic          irq,
  output logic          irq_chg
);
  logic [DW-1:0] vec_r, mstr_r, vec_mod, rd_r;
  logic [NCH-1:0] req, cd_lvl;
  logic [DW-1:0] stat [NCH];
  logic irq_r, chg_r, irq_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sirq_chan u_ch (
      .clk(clk), .rst(rst), .cd_in(cd_in[c]),
      .wr_en(wr_en && (chan == c[0])), .reg_idx(reg_idx), .wr_data(wr_data),
      .req(req[c]), .cd_lvl(cd_lvl[c]), .stat(stat[c])
    );
  end

  sirq_vec u_vec (.vec(vec_r), .hi_pos(mstr_r[BIT_HIPOS]), .req(req), .vec_out(vec_mod));

  assign irq_d = mstr_r[BIT_MIE] && (|req);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_r  <= '0;
      mstr_r <= '0;
      rd_r   <= '0;
      irq_r  <= 1'b0;
      chg_r  <= 1'b0;
    end else begin
      if (wr_en && reg_idx == IDX_VEC)  vec_r  <= wr_data;
      if (wr_en && reg_idx == IDX_MSTR) mstr_r <= wr_data;
      irq_r <= irq_d;
      chg_r <= irq_d != irq_r;
      if (rd_en) begin
        case (reg_idx)
          IDX_CMD: rd_r <= {4'b0, cd_lvl[chan], 3'b0};
          IDX_VEC: rd_r <= chan ? vec_r : vec_mod;
          IDX_EXT: rd_r <= stat[chan];
          default: rd_r <= '0;
        endcase
      end
    end
  end

  assign rd_data = rd_r;
  assign irq     = irq_r;
  assign irq_chg = chg_r;

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
    irq_r |-> $past(mstr_r[BIT_MIE]));
  assert_chg_marks_R9: assert property (@(posedge clk) disable iff (rst)
    chg_r |-> (irq_r != $past(irq_r)));
  assert_chg_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !chg_r |-> (irq_r == $past(irq_r)));
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_r));
endmodule

// File: tb/sirq_top_bench.sv
module sirq_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan = 1'b0;
  logic [3:0] reg_idx = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] cd_in = 2'b00;
  logic irq, irq_chg;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  sirq_top u_sirq_top (.clk(clk), .rst(rst), .chan(chan), .reg_idx(reg_idx),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .cd_in(cd_in), .irq(irq), .irq_chg(irq_chg));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    chan = ch; reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic ch, input logic [3:0] idx, output logic [7:0] d);
    @(negedge clk);
    chan = ch; reg_idx = idx; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cd_in = 2'b11;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 irq_chg", {7'b0, irq_chg}, 8'h00);
    wr(0, 4'd15, 8'h08); wr(1, 4'd15, 8'h08);
    repeat (2) @(negedge clk);
    rd(0, 4'd15, d); chk("R1 no spurious ch0", d, 8'h00);
    rd(1, 4'd15, d); chk("R1 no spurious ch1", d, 8'h00);
    rd(1, 4'd2, d);  chk("R1 vector clear", d, 8'h00);
    // R8 carrier level and unused index
    rd(0, 4'd0, d);  chk("R8 cd level", d, 8'h08);
    rd(0, 4'd5, d);  chk("R8 unused index", d, 8'h00);
    // R3 rewriting same level: no event
    @(negedge clk); cd_in = 2'b11;
    repeat (2) @(negedge clk);
    rd(0, 4'd15, d); chk("R3 steady level", d, 8'h00);
    // R4 simultaneous change and clear: change wins
    @(negedge clk);
    chan = 0; reg_idx = 4'd0; wr_data = 8'h10; wr_en = 1'b1; cd_in = 2'b10;
    @(negedge clk); wr_en = 1'b0;
    rd(0, 4'd15, d); chk("R4 change beats clear", d, 8'h08);
    wr(0, 4'd0, 8'h10);
    rd(0, 4'd15, d); chk("R4 clear", d, 8'h00);
    // R10 data held without read strobe
    rd(0, 4'd0, d);
    repeat (3) @(negedge clk);
    chk("R10 hold", rd_data, d);

    // sweep R2 R5 R6 R7 R8 R9
    for (int it = 0; it < 256; it++) begin
      logic [1:0] mb, en, cap, fl, pend, rq;
      logic [7:0] vec, ev, mval;
      logic eirq;
      int sh, pulses;
      mb = it[1:0]; en = it[3:2]; cap = it[5:4]; fl = it[7:6];
      vec = it[0] ? 8'hFF : 8'h00;
      vec = vec ^ it[7:0];
      mval = {3'b0, mb[1], mb[0], 3'b0};
      wr(0, 4'd1, 8'h00); wr(1, 4'd1, 8'h00);
      wr(0, 4'd9, mval);
      wr(1, 4'd2, vec);
      wr(0, 4'd0, 8'h10); wr(1, 4'd0, 8'h10);
      wr(0, 4'd15, {4'b0, cap[0], 3'b0}); wr(1, 4'd15, {4'b0, cap[1], 3'b0});
      wr(0, 4'd1, {7'b0, en[0]}); wr(1, 4'd1, {7'b0, en[1]});
      @(negedge clk);
      cd_in = cd_in ^ fl;
      pulses = 0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (irq_chg) pulses++;
      end
      pend = fl & cap;
      rq = pend & en;
      eirq = mb[0] && (rq != 2'b00);
      chk("R6 irq", {7'b0, irq}, {7'b0, eirq});
      chk("R9 pulse count", 8'(pulses), {7'b0, eirq});
      sh = mb[1] ? 4 : 1;
      ev = vec;
      if (rq != 2'b00) begin
        ev = ev & ~(8'h07 << sh);
        ev = ev | ((rq[0] ? 8'h01 : 8'h05) << sh);
      end
      rd(0, 4'd2, d); chk("R7 merged vector", d, ev);
      rd(1, 4'd2, d); chk("R8 raw vector ch1", d, vec);
      rd(0, 4'd15, d); chk("R2 status ch0", d, pend[0] ? 8'h08 : 8'h00);
      rd(1, 4'd15, d); chk("R2 status ch1", d, pend[1] ? 8'h08 : 8'h00);
      rd(1, 4'd0, d); chk("R8 cd ch1", d, {4'b0, cd_in[1], 3'b0});
      if (it == 255) chk("R5 request gating", {7'b0, irq}, 8'h01);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule